// File: doc/BRIEF.md
# Command Queue Priority Aging

This block keeps a short ordered list of pending memory commands, each carrying a small priority value where a lower number means more urgent. The entry in slot 0 is the head, which a downstream scheduler consumes with a pop. A newly pushed command is placed into the list by comparing its priority with the priorities the queued entries hold at that moment.

Waiting commands are protected from starvation by a two-tier aging scheme. A free-running rate timer emits a one-cycle tick once every `age_rate_i` cycles. Each slot also holds its own wait counter. The counter is loaded from `entry_age_i` when the command is inserted and steps down on every tick. When it runs out, the command's priority value drops by one and the counter reloads. An aged entry keeps its place in the list. Its new priority only affects where later arrivals are placed.

Top module: `cmdq_age_top`

## Requirements
- R1: During and right after a synchronous active-high reset the queue is empty: `head_valid_o`=0, `slot_valid_o`=0 and `full_o`=0.
- R2: Occupied slots are contiguous from slot 0, and the head outputs show slot 0. A pushed command is placed directly behind the last occupied slot whose priority value is less than or equal to its own, or in slot 0 if there is no such slot. Equal priorities therefore keep arrival order.
- R3: The rate timer starts from reset and ticks at the end of every `age_rate_i`-th cycle. An aging step therefore lands on the clock edges that follow those ticks.
- R4: A slot's wait counter is loaded with `entry_age_i` at insertion and decremented on each tick. On the tick that finds the counter at 1 or below, the priority value drops by one and the counter reloads from `entry_age_i`. A command therefore gains one level for every `age_rate_i` × `entry_age_i` cycles it waits.
- R5: A priority value of 0 stays at 0 under aging and never wraps.
- R6: Aging never moves an entry. Order changes only through push and pop.
- R7: The placement of a push uses the aged priorities held in the slots, not the priorities the entries had when they were inserted.
- R8: A push while `full_o` is high is dropped, including in a cycle that also pops.
- R9: A pop while the queue is empty has no effect.
- R10: A pop removes slot 0 and moves every other entry forward by one. A push in the same cycle is then placed among the remaining entries.
- R11: A reload value of 0 on either input acts as 1. With `age_rate_i`=0 the timer ticks every cycle, and with `entry_age_i`=0 a command gains a level on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Insert a command this cycle |
| push_cmd_i | input | CMD_W | Command payload to insert |
| push_prio_i | input | PRIO_W | Initial priority value, 0 is most urgent |
| pop_i | input | 1 | Remove the head entry |
| age_rate_i | input | CNT_W | Cycles between rate-timer ticks |
| entry_age_i | input | CNT_W | Ticks a command waits per priority level |
| head_valid_o | output | 1 | Slot 0 holds a command |
| head_cmd_o | output | CMD_W | Command in slot 0 |
| head_prio_o | output | PRIO_W | Current priority of slot 0 |
| slot_valid_o | output | DEPTH | Occupancy per slot, bit i is slot i |
| slot_prio_o | output | DEPTH*PRIO_W | Priority of slot i at bits [i*PRIO_W +: PRIO_W] |
| full_o | output | 1 | Every slot is occupied |

## Verification
The hardest situation to reach is an aged entry sitting behind a less urgent one. Because older entries age first, this case does not arise from ordinary traffic. The stimulus builds it by inserting the first command with a very long wait reload. It then switches `entry_age_i` to 1 before inserting a less urgent second command, which soon overtakes the first in priority value while staying behind it. A third push is then placed according to the aged values, which lands it at the tail rather than at the front.

// File: rtl/cmdq_age_pkg.sv
package cmdq_age_pkg;
  localparam int unsigned DEF_DEPTH  = 8;
  localparam int unsigned DEF_CMD_W  = 8;
  localparam int unsigned DEF_PRIO_W = 2;
  localparam int unsigned DEF_CNT_W  = 8;

  // where a slot takes its next contents from
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,  // same index of the post-pop view
    SRC_NEW  = 2'd1,  // the pushed command
    SRC_BACK = 2'd2   // previous index of the post-pop view
  } slot_src_e;
endpackage

// File: rtl/cmdq_age_timer.sv
module cmdq_age_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rate_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = (rate_i == '0) ? '0 : rate_i - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= limit) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && rate_i > CNT_W'(1)) |=> !tick_o);

  // R11
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_i == '0) |=> tick_o);
endmodule

// File: rtl/cmdq_age_step.sv
module cmdq_age_step #(
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              tick_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    prio_o = prio_i;
    cnt_o  = cnt_i;
    if (tick_i) begin
      if (cnt_i <= CNT_W'(1)) begin
        cnt_o = reload_i;
        if (prio_i != '0) prio_o = prio_i - PRIO_W'(1);
      end else begin
        cnt_o = cnt_i - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cmdq_age_store.sv
module cmdq_age_store
  import cmdq_age_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick_i,
  input  logic [CNT_W-1:0]              reload_i,
  input  logic                          push_i,
  input  logic [CMD_W-1:0]              push_cmd_i,
  input  logic [PRIO_W-1:0]             push_prio_i,
  input  logic                          pop_i,
  output logic [DEPTH-1:0][CMD_W-1:0]   cmd_o,
  output logic [DEPTH-1:0][PRIO_W-1:0]  prio_o,
  output logic [DEPTH-1:0]              valid_o
);
  logic [DEPTH-1:0][CMD_W-1:0]  cmd_q;
  logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
  logic [DEPTH-1:0][CNT_W-1:0]  wait_q;
  logic [DEPTH-1:0]             valid_q;

  // aged view of every slot
  logic [DEPTH-1:0][PRIO_W-1:0] aged_prio;
  logic [DEPTH-1:0][CNT_W-1:0]  aged_wait;

  // view after an accepted pop
  logic [DEPTH-1:0][CMD_W-1:0]  sh_cmd;
  logic [DEPTH-1:0][PRIO_W-1:0] sh_prio;   // aged
  logic [DEPTH-1:0][PRIO_W-1:0] sh_cur;    // pre-aging, used for placement
  logic [DEPTH-1:0][CNT_W-1:0]  sh_wait;
  logic [DEPTH-1:0]             sh_valid;

  // same view taken one index lower, for slots that move back
  logic [DEPTH-1:0][CMD_W-1:0]  pv_cmd;
  logic [DEPTH-1:0][PRIO_W-1:0] pv_prio;
  logic [DEPTH-1:0][CNT_W-1:0]  pv_wait;
  logic [DEPTH-1:0]             pv_valid;
  logic [DEPTH-1:0]             pv_keep;

  logic [DEPTH-1:0] keep;
  slot_src_e        src [DEPTH];

  logic pop_acc;
  logic push_acc;

  assign pop_acc  = pop_i & valid_q[0];
  assign push_acc = push_i & ~valid_q[DEPTH-1];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    cmdq_age_step #(.PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_step (
      .tick_i   (tick_i),
      .prio_i   (prio_q[g]),
      .cnt_i    (wait_q[g]),
      .reload_i (reload_i),
      .prio_o   (aged_prio[g]),
      .cnt_o    (aged_wait[g])
    );

    if (g < DEPTH-1) begin : g_mid
      assign sh_cmd[g]   = pop_acc ? cmd_q[g+1]     : cmd_q[g];
      assign sh_prio[g]  = pop_acc ? aged_prio[g+1] : aged_prio[g];
      assign sh_cur[g]   = pop_acc ? prio_q[g+1]    : prio_q[g];
      assign sh_wait[g]  = pop_acc ? aged_wait[g+1] : aged_wait[g];
      assign sh_valid[g] = pop_acc ? valid_q[g+1]   : valid_q[g];
    end else begin : g_last
      assign sh_cmd[g]   = pop_acc ? '0   : cmd_q[g];
      assign sh_prio[g]  = pop_acc ? '0   : aged_prio[g];
      assign sh_cur[g]   = pop_acc ? '0   : prio_q[g];
      assign sh_wait[g]  = pop_acc ? '0   : aged_wait[g];
      assign sh_valid[g] = pop_acc ? 1'b0 : valid_q[g];
    end

    if (g == 0) begin : g_first
      assign pv_cmd[g]   = '0;
      assign pv_prio[g]  = '0;
      assign pv_wait[g]  = '0;
      assign pv_valid[g] = 1'b0;
      assign pv_keep[g]  = 1'b1;
    end else begin : g_rest
      assign pv_cmd[g]   = sh_cmd[g-1];
      assign pv_prio[g]  = sh_prio[g-1];
      assign pv_wait[g]  = sh_wait[g-1];
      assign pv_valid[g] = sh_valid[g-1];
      assign pv_keep[g]  = keep[g-1];
    end
  end

  // keep[i]: some occupied slot at or after i is no less urgent than the push
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      run     = run | (sh_valid[i] && (sh_cur[i] <= push_prio_i));
      keep[i] = run;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!push_acc || keep[i])  src[i] = SRC_HOLD;
      else if (pv_keep[i])       src[i] = SRC_NEW;
      else                       src[i] = SRC_BACK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      prio_q  <= '0;
      wait_q  <= '0;
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        case (src[i])
          SRC_NEW: begin
            cmd_q[i]   <= push_cmd_i;
            prio_q[i]  <= push_prio_i;
            wait_q[i]  <= reload_i;
            valid_q[i] <= 1'b1;
          end
          SRC_BACK: begin
            cmd_q[i]   <= pv_cmd[i];
            prio_q[i]  <= pv_prio[i];
            wait_q[i]  <= pv_wait[i];
            valid_q[i] <= pv_valid[i];
          end
          default: begin
            cmd_q[i]   <= sh_cmd[i];
            prio_q[i]  <= sh_prio[i];
            wait_q[i]  <= sh_wait[i];
            valid_q[i] <= sh_valid[i];
          end
        endcase
      end
    end
  end

  assign cmd_o   = cmd_q;
  assign prio_o  = prio_q;
  assign valid_o = valid_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q[DEPTH-1] && push_i && !pop_i) |=> (valid_q == $past(valid_q)));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q[0] && pop_i && !push_i) |=> !valid_q[0]);

  // R6
  still_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> $stable(cmd_q));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    if (g > 0) begin : g_contig
      // R2
      contig_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q[g] |-> valid_q[g-1]);
    end

    // R4
    age_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!push_i && !pop_i && valid_q[g]) |=>
        (prio_q[g] == $past(prio_q[g]) ||
         ({1'b0, prio_q[g]} + 1'b1) == {1'b0, $past(prio_q[g])}));

    // R5
    floor_chk: assert property (@(posedge clk) disable iff (rst)
      (!push_i && !pop_i && valid_q[g] && prio_q[g] == '0) |=> (prio_q[g] == '0));
  end
endmodule

// File: rtl/cmdq_age_top.sv
module cmdq_age_top
  import cmdq_age_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned CMD_W  = DEF_CMD_W,
  parameter int unsigned PRIO_W = DEF_PRIO_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push_i,
  input  logic [CMD_W-1:0]        push_cmd_i,
  input  logic [PRIO_W-1:0]       push_prio_i,
  input  logic                    pop_i,
  input  logic [CNT_W-1:0]        age_rate_i,
  input  logic [CNT_W-1:0]        entry_age_i,
  output logic                    head_valid_o,
  output logic [CMD_W-1:0]        head_cmd_o,
  output logic [PRIO_W-1:0]       head_prio_o,
  output logic [DEPTH-1:0]        slot_valid_o,
  output logic [DEPTH*PRIO_W-1:0] slot_prio_o,
  output logic                    full_o
);
  logic                         tick;
  logic [CNT_W-1:0]             reload_eff;
  logic [DEPTH-1:0][CMD_W-1:0]  cmd_w;
  logic [DEPTH-1:0][PRIO_W-1:0] prio_w;
  logic [DEPTH-1:0]             valid_w;

  assign reload_eff = (entry_age_i == '0) ? CNT_W'(1) : entry_age_i;

  cmdq_age_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .rate_i (age_rate_i),
    .tick_o (tick)
  );

  cmdq_age_store #(
    .DEPTH(DEPTH), .CMD_W(CMD_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .reload_i    (reload_eff),
    .push_i      (push_i),
    .push_cmd_i  (push_cmd_i),
    .push_prio_i (push_prio_i),
    .pop_i       (pop_i),
    .cmd_o       (cmd_w),
    .prio_o      (prio_w),
    .valid_o     (valid_w)
  );

  assign head_valid_o = valid_w[0];
  assign head_cmd_o   = cmd_w[0];
  assign head_prio_o  = prio_w[0];
  assign slot_valid_o = valid_w;
  assign slot_prio_o  = prio_w;
  assign full_o       = valid_w[DEPTH-1];

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (!head_valid_o && slot_valid_o == '0));
endmodule

// File: tb/cmdq_age_top_tb.sv
module cmdq_age_top_tb;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 1'b0;
  logic [7:0] push_cmd_i = '0;
  logic [1:0] push_prio_i = '0;
  logic       pop_i = 1'b0;
  logic [7:0] age_rate_i = 8'd200;
  logic [7:0] entry_age_i = 8'd255;
  logic       head_valid_o;
  logic [7:0] head_cmd_o;
  logic [1:0] head_prio_o;
  logic [7:0] slot_valid_o;
  logic [15:0] slot_prio_o;
  logic       full_o;

  always #10 clk = ~clk;  // 50 MHz

  cmdq_age_top u_dut (
    .clk(clk), .rst(rst), .push_i(push_i), .push_cmd_i(push_cmd_i),
    .push_prio_i(push_prio_i), .pop_i(pop_i), .age_rate_i(age_rate_i),
    .entry_age_i(entry_age_i), .head_valid_o(head_valid_o),
    .head_cmd_o(head_cmd_o), .head_prio_o(head_prio_o),
    .slot_valid_o(slot_valid_o), .slot_prio_o(slot_prio_o), .full_o(full_o)
  );

  typedef struct { int cmd; int prio; int wcnt; } ent_t;
  typedef struct {
    bit hv; int hcmd; int hprio; int sv; int sp; bit full; string tag;
  } snap_t;

  ent_t  mq[$];
  snap_t exp_q[$];
  int    mcnt = 0;
  bit    mtick = 0;
  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model: next state from the requirements
  task automatic model_edge(bit push, int cmd, int prio, bit pop);
    int   a, c, ceff, lim, pos;
    ent_t cur[$];
    ent_t nxt[$];
    ent_t e;
    a    = age_rate_i;
    c    = entry_age_i;
    ceff = (c == 0) ? 1 : c;
    lim  = (a == 0) ? 0 : a - 1;
    cur  = mq;
    foreach (cur[i]) begin
      e = cur[i];
      if (mtick) begin
        if (e.wcnt <= 1) begin
          if (e.prio > 0) e.prio--;
          e.wcnt = ceff;
        end else e.wcnt--;
      end
      nxt.push_back(e);
    end
    if (pop && cur.size() > 0) begin
      void'(cur.pop_front());
      void'(nxt.pop_front());
    end
    if (push && mq.size() < DEPTH) begin
      pos = 0;
      foreach (cur[i]) if (cur[i].prio <= prio) pos = i + 1;
      e.cmd = cmd; e.prio = prio; e.wcnt = ceff;
      nxt.insert(pos, e);
    end
    mq = nxt;
    if (mcnt >= lim) begin mcnt = 0; mtick = 1; end
    else begin mcnt++; mtick = 0; end
  endtask

  function automatic snap_t snapshot();
    snap_t s;
    s.hv = mq.size() > 0;
    s.hcmd = s.hv ? mq[0].cmd : 0;
    s.hprio = s.hv ? mq[0].prio : 0;
    s.sv = 0; s.sp = 0;
    foreach (mq[i]) begin
      s.sv |= (1 << i);
      s.sp |= (mq[i].prio << (2 * i));
    end
    s.full = mq.size() == DEPTH;
    s.tag = cur_req;
    return s;
  endfunction

  // driver: starts and ends at a falling edge
  task automatic step(bit push, int cmd, int prio, bit pop);
    push_i = push; push_cmd_i = cmd[7:0]; push_prio_i = prio[1:0]; pop_i = pop;
    model_edge(push, cmd, prio, pop);
    @(posedge clk);
    #1;
    exp_q.push_back(snapshot());
    @(negedge clk);
    push_i = 0; pop_i = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  // monitor: compares outputs with the expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      snap_t s;
      int mask;
      s = exp_q.pop_front();
      mask = 0;
      for (int i = 0; i < DEPTH; i++) if (s.sv[i]) mask |= (3 << (2 * i));
      check(head_valid_o == s.hv, s.tag, "head_valid", head_valid_o, s.hv);
      if (s.hv) begin
        check(head_cmd_o == s.hcmd[7:0], s.tag, "head_cmd", head_cmd_o, s.hcmd);
        check(head_prio_o == s.hprio[1:0], s.tag, "head_prio", head_prio_o, s.hprio);
      end
      check(slot_valid_o == s.sv[7:0], s.tag, "slot_valid", slot_valid_o, s.sv);
      check((int'(slot_prio_o) & mask) == s.sp, s.tag, "slot_prio",
            int'(slot_prio_o) & mask, s.sp);
      check(full_o == s.full, s.tag, "full", full_o, s.full);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!head_valid_o, "R1", "head_valid in reset", head_valid_o, 0);
    rst = 0;
    check(slot_valid_o == 0, "R1", "slot_valid after reset", slot_valid_o, 0);
    check(!full_o, "R1", "full after reset", full_o, 0);

    // placement by priority, FIFO among equals (no aging within this phase)
    cur_req = "R2";
    step(1, 'h11, 2, 0);
    step(1, 'h12, 1, 0);
    step(1, 'h13, 3, 0);
    step(1, 'h14, 1, 0);
    step(1, 'h15, 0, 0);
    idle(2);
    cur_req = "R10";
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1);

    // fill, overflow, push with pop when full
    cur_req = "R8";
    for (int k = 0; k < DEPTH; k++) step(1, 'h20 + k, k % 4, 0);
    step(1, 'h99, 0, 0);
    step(1, 'h9a, 0, 1);
    cur_req = "R10";
    step(1, 'h30, 1, 1);
    step(1, 'h31, 3, 1);
    cur_req = "R9";
    for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 1);
    step(0, 0, 0, 1);

    // aging timing, reload and floor
    cur_req = "R3";
    age_rate_i = 8'd3; entry_age_i = 8'd2;
    step(1, 'h50, 3, 0);
    idle(14);
    cur_req = "R4";
    idle(14);
    cur_req = "R5";
    idle(12);
    step(0, 0, 0, 1);

    // zero reload values act as one
    cur_req = "R11";
    age_rate_i = 8'd0; entry_age_i = 8'd0;
    step(1, 'h51, 3, 0);
    idle(5);
    step(0, 0, 0, 1);

    // aged entry stays behind a less urgent one, placement uses aged values
    cur_req = "R6";
    age_rate_i = 8'd2; entry_age_i = 8'd255;
    step(1, 'h60, 2, 0);
    entry_age_i = 8'd1;
    step(1, 'h61, 3, 0);
    idle(12);
    cur_req = "R7";
    step(1, 'h62, 1, 0);
    idle(2);
    cur_req = "R10";
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule